// File: doc/BRIEF.md
# Rail Source Handover Sequencer

This block decides, cycle by cycle, which of two supply sources feeds each of two output rails, and it enforces safe timing whenever a rail moves from one source to the other. Each rail can take power from a main source or from a standby source, and each has its own pair of gate enables. The "dual" rail must never have both sources connected: a move opens the old path, waits a dead time, then closes the new one. The "adjustable" rail must never lose its supply during a move: it closes the new path first, keeps both paths on for an overlap time, then opens the old one.

Each rail is steered by two plain control pins: an enable and a source select. All timings are parameters counted in clock cycles. The dead time depends on the direction of the move, while the overlap time is the same in both directions. A global kill input forces every enable low in the same cycle, without waiting for a clock edge, and abandons any move in progress. There is no data stream and no handshake; every pin is a level.

Top module: `rail_handover_seq`

## Requirements
- R1: The two dual-rail enables (`dual_main_on`, `dual_stby_on`) are never high in the same cycle.
- R2: When the dual rail is powered from main (`dual_req_en`=1, `dual_req_main`=1) and the select is sampled as 0 (standby) at a rising edge, `dual_main_on` falls after that edge. Both dual enables then stay low for exactly `DEAD_MAIN_TO_STBY` cycles before `dual_stby_on` rises.
- R3: A dual-rail move from standby to main works the same way as R2, with both enables low for exactly `DEAD_STBY_TO_MAIN` cycles.
- R4: When the adjustable rail is powered and its select changes, the newly chosen enable rises right after the edge that samples the change. Both adjustable enables then stay high for exactly `OVERLAP` cycles, after which the old enable falls. This holds in both directions.
- R5: The source select is encoded as 1 = main and 0 = standby. An enable of 0 means the rail is off. From off, a rising edge that samples enable=1 turns on the selected source right after that edge, with no delay. A powered rail that samples enable=0 goes off right after that edge, with no delay.
- R6: A request change that arrives during a dead-time or overlap window is ignored until that window ends. The request present when the window ends is then acted on, which may start a new move.
- R7: While `kill` is high, all four enables are low in that same cycle. Any move in progress is abandoned. In the first cycle after `kill` falls, both rails are off and they restart as described in R5.
- R8: During and right after reset (`rst_n` low), all four enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kill | input | 1 | Global shutdown; gates all enables low at once |
| dual_req_en | input | 1 | Dual rail wanted on |
| dual_req_main | input | 1 | Dual rail source: 1 main, 0 standby |
| adj_req_en | input | 1 | Adjustable rail wanted on |
| adj_req_main | input | 1 | Adjustable rail source: 1 main, 0 standby |
| dual_main_on | output | 1 | Gate enable, dual rail main path |
| dual_stby_on | output | 1 | Gate enable, dual rail standby path |
| adj_main_on | output | 1 | Gate enable, adjustable rail main path |
| adj_stby_on | output | 1 | Gate enable, adjustable rail standby path |

## Verification
A wrong lane state shows up at the enables in the very next cycle. A lane stuck in its move state keeps both dual enables low, or both adjustable enables high, past the expected window. A lane that skips the move state shows the two enables touching in the same cycle or in adjacent cycles. A timer that is off by one moves the edge of the new enable by one cycle. Because the bench compares all four enables against its model on every cycle, such a slip is reported in the cycle it appears. A kill that does not clear the stored state becomes visible in the first cycle after release, as a rail coming back on with no fresh request.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_MAIN = 2'd1,
    LANE_STBY = 2'd2,
    LANE_MOVE = 2'd3
  } lane_st_t;
endpackage

// File: rtl/handover_timer.sv
module handover_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (clr)            left_q <= '0;
    else if (load)           left_q <= load_val;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign expired = (left_q == '0);
endmodule

// File: rtl/handover_lane.sv
module handover_lane
  import rail_seq_pkg::*;
#(
  parameter int unsigned TIME_FROM_MAIN = 8,
  parameter int unsigned TIME_FROM_STBY = 4,
  parameter bit          MAKE_FIRST     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic req_en,
  input  logic req_main,
  output logic main_on,
  output logic stby_on
);
  localparam int unsigned TMAX = (TIME_FROM_MAIN > TIME_FROM_STBY) ? TIME_FROM_MAIN : TIME_FROM_STBY;
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LOAD_FROM_MAIN = CW'(TIME_FROM_MAIN - 1);
  localparam logic [CW-1:0] LOAD_FROM_STBY = CW'(TIME_FROM_STBY - 1);

  lane_st_t      st_q, st_d;
  logic          tgt_main_q, tgt_main_d;
  logic          start_move;
  logic [CW-1:0] load_val;
  logic          expired;

  always_comb begin
    st_d       = st_q;
    tgt_main_d = tgt_main_q;
    start_move = 1'b0;
    load_val   = LOAD_FROM_STBY;
    unique case (st_q)
      LANE_OFF: begin
        if (req_en) st_d = req_main ? LANE_MAIN : LANE_STBY;
      end
      LANE_MAIN, LANE_STBY: begin
        if (!req_en) begin
          st_d = LANE_OFF;
        end else if (req_main != (st_q == LANE_MAIN)) begin
          st_d       = LANE_MOVE;
          tgt_main_d = req_main;
          start_move = 1'b1;
          load_val   = (st_q == LANE_MAIN) ? LOAD_FROM_MAIN : LOAD_FROM_STBY;
        end
      end
      LANE_MOVE: begin
        if (expired) st_d = tgt_main_q ? LANE_MAIN : LANE_STBY;
      end
      default: st_d = LANE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      st_q       <= LANE_OFF;
      tgt_main_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      tgt_main_q <= tgt_main_d;
    end
  end

  handover_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (kill),
    .load     (start_move),
    .load_val (load_val),
    .expired  (expired)
  );

  generate
    if (MAKE_FIRST) begin : g_overlap
      assign main_on = (st_q == LANE_MAIN) || (st_q == LANE_MOVE);
      assign stby_on = (st_q == LANE_STBY) || (st_q == LANE_MOVE);
    end else begin : g_dead
      assign main_on = (st_q == LANE_MAIN);
      assign stby_on = (st_q == LANE_STBY);
    end
  endgenerate
endmodule

// File: rtl/rail_handover_seq.sv
module rail_handover_seq #(
  parameter int unsigned DEAD_MAIN_TO_STBY = 1000,
  parameter int unsigned DEAD_STBY_TO_MAIN = 125,
  parameter int unsigned OVERLAP           = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic dual_req_en,
  input  logic dual_req_main,
  input  logic adj_req_en,
  input  logic adj_req_main,
  output logic dual_main_on,
  output logic dual_stby_on,
  output logic adj_main_on,
  output logic adj_stby_on
);
  logic dual_main_q, dual_stby_q, adj_main_q, adj_stby_q;

  handover_lane #(
    .TIME_FROM_MAIN (DEAD_MAIN_TO_STBY),
    .TIME_FROM_STBY (DEAD_STBY_TO_MAIN),
    .MAKE_FIRST     (1'b0)
  ) u_dual (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (kill),
    .req_en   (dual_req_en),
    .req_main (dual_req_main),
    .main_on  (dual_main_q),
    .stby_on  (dual_stby_q)
  );

  handover_lane #(
    .TIME_FROM_MAIN (OVERLAP),
    .TIME_FROM_STBY (OVERLAP),
    .MAKE_FIRST     (1'b1)
  ) u_adj (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (kill),
    .req_en   (adj_req_en),
    .req_main (adj_req_main),
    .main_on  (adj_main_q),
    .stby_on  (adj_stby_q)
  );

  assign dual_main_on = dual_main_q & ~kill;
  assign dual_stby_on = dual_stby_q & ~kill;
  assign adj_main_on  = adj_main_q  & ~kill;
  assign adj_stby_on  = adj_stby_q  & ~kill;
endmodule

// File: rtl/rail_handover_seq_chk.sv
module rail_handover_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic kill,
  input logic dm,
  input logic ds,
  input logic am,
  input logic as_
);
  assert_dual_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm && ds));

  assert_gap_before_stby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds) |-> !$past(dm));

  assert_gap_before_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dm) |-> !$past(ds));

  assert_adj_keep_stby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(am) && as_) |-> $past(as_));

  assert_adj_keep_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_) && am) |-> $past(am));

  assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(dm || ds || am || as_));

  assert_kill_release_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kill) |-> !(dm || ds || am || as_));
endmodule

bind rail_handover_seq rail_handover_seq_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .kill (kill),
  .dm   (dual_main_on),
  .ds   (dual_stby_on),
  .am   (adj_main_on),
  .as_  (adj_stby_on)
);

// File: tb/rail_handover_seq_test.sv
`timescale 1ns/1ps
module rail_handover_seq_test;
  localparam int DMS = 1000;
  localparam int DSM = 125;
  localparam int OVL = 750;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kill = 1'b0;
  logic d_en = 1'b0, d_main = 1'b0, a_en = 1'b0, a_main = 1'b0;
  logic dm, ds, am, as_;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R8";

  always #2 clk = ~clk;

  rail_handover_seq #(
    .DEAD_MAIN_TO_STBY(DMS), .DEAD_STBY_TO_MAIN(DSM), .OVERLAP(OVL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .kill(kill),
    .dual_req_en(d_en), .dual_req_main(d_main),
    .adj_req_en(a_en), .adj_req_main(a_main),
    .dual_main_on(dm), .dual_stby_on(ds),
    .adj_main_on(am), .adj_stby_on(as_)
  );

  // Behavioural reference: phase 0 off, 1 main, 2 standby, 3 switching
  int d_ph = 0, d_go_main = 0, d_left = 0;
  int a_ph = 0, a_go_main = 0, a_left = 0;

  always @(posedge clk) begin
    if (!rst_n || kill) begin
      d_ph = 0; a_ph = 0;
    end else begin
      if (d_ph == 3) begin
        d_left--; if (d_left == 0) d_ph = d_go_main ? 1 : 2;
      end else if (!d_en) d_ph = 0;
      else if (d_ph == 0) d_ph = d_main ? 1 : 2;
      else if ((d_ph == 1) != d_main) begin
        d_left = (d_ph == 1) ? DMS : DSM; d_go_main = d_main; d_ph = 3;
      end
      if (a_ph == 3) begin
        a_left--; if (a_left == 0) a_ph = a_go_main ? 1 : 2;
      end else if (!a_en) a_ph = 0;
      else if (a_ph == 0) a_ph = a_main ? 1 : 2;
      else if ((a_ph == 1) != a_main) begin
        a_left = OVL; a_go_main = a_main; a_ph = 3;
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] exp_v, got_v;
    #1;
    if (!done) begin
      exp_v[3] = (d_ph == 1) && !kill;
      exp_v[2] = (d_ph == 2) && !kill;
      exp_v[1] = ((a_ph == 1) || (a_ph == 3)) && !kill;
      exp_v[0] = ((a_ph == 2) || (a_ph == 3)) && !kill;
      got_v = {dm, ds, am, as_};
      total++;
      if (got_v !== exp_v) begin
        bad++;
        $display("FAIL %s t=%0t enables actual=%b expected=%b", tag, $time, got_v, exp_v);
      end
      total++;
      if (dm && ds) begin
        bad++;
        $display("FAIL R1 both dual enables high actual=11 expected=not 11");
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    hold(4);                                // R8 reset state checked
    rst_n = 1'b1;
    tag = "R5"; d_en = 1; d_main = 1; a_en = 1; a_main = 0; hold(6);
    tag = "R2"; d_main = 0; hold(DMS + 10);
    tag = "R3"; d_main = 1; hold(DSM + 10);
    tag = "R4"; a_main = 1; hold(OVL + 10);
    a_main = 0; hold(OVL + 10);
    tag = "R6"; d_main = 0; hold(100);
    d_main = 1; hold(50); d_en = 0; hold(20); d_en = 1;
    hold(DMS + DSM + 20);
    a_main = 1; hold(10); a_en = 0; hold(OVL + 10);
    a_en = 1; hold(5);
    tag = "R7"; a_main = 0; d_main = 0; hold(40);
    kill = 1; hold(3); kill = 0; hold(20);
    kill = 1; hold(1); a_main = 1; kill = 0; hold(OVL + 20);
    tag = "R5"; d_en = 0; a_en = 0; hold(5);
    d_en = 1; d_main = 0; hold(5);
    tag = "R8"; rst_n = 0; hold(3); rst_n = 1; d_en = 0; hold(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule